// File: doc/BRIEF.md
# Narrow-Bus Pixel Serializer with Reassembly Pipeline

This block moves pixel words across a narrow data bus into a small logic stage that rebuilds them for a wide TFT panel input. An upstream source offers one pixel at a time through a valid/ready handshake. The serializer turns each pixel into one, two or three bus beats, depending on the colour format. The reassembly side captures the beats through a registered pipeline and presents the rebuilt word along with a one-cycle strobe.

There are three formats. The first is a pass-through mode for a native 16-bit bus, with one beat per pixel and no added delay. The second is RGB565 over the 8-bit byte lane, with two beats per pixel. The third is RGB888 over the byte lane, with three beats per pixel. An optional colour-order swap exchanges the red and blue fields before the word is sent.

The block publishes the fixed latency of the current format, so the sync generator can shift its timing to match. A line-start pulse clears any partly sent or partly rebuilt pixel, so a misaligned byte never runs over into the next line.

Top module: `pxs_narrow_bus_top`

## Requirements
- R1: `mode_sel` selects the format: 2'b00 native 16-bit, 2'b01 RGB565 on the byte lane, 2'b10 RGB888 on the byte lane, and 2'b11 acts as native 16-bit. A pixel takes 1, 2 or 3 bus beats in these formats. With `pix_valid` held high, pixels are accepted every 1, 2 or 3 cycles. The first beat is on the bus in the cycle after acceptance, and the beats of one pixel follow without a gap.
- R2: In RGB565 mode the beats carry `pix_data[15:8]` and then `pix_data[7:0]` on `bus_data[7:0]`, most significant byte first, with `bus_data[15:8]` at zero.
- R3: In RGB888 mode the beats carry `pix_data[23:16]`, then `pix_data[15:8]`, then `pix_data[7:0]` on `bus_data[7:0]`, with `bus_data[15:8]` at zero.
- R4: In native mode `bus_data` carries `pix_data[15:0]` in a single beat. `out_valid` equals `bus_en` in the same cycle, and `out_pix` equals `{8'h00, bus_data}`.
- R5: When `bgr_en` is 1, red and blue are exchanged before sending. In the 16-bit formats the fields are red at [15:11], green at [10:5] and blue at [4:0], and [15:11] is exchanged with [4:0]. In RGB888, bits [23:16] are exchanged with bits [7:0].
- R6: `latency` reads 0 in native mode, 3 in RGB565 mode and 5 in RGB888 mode.
- R7: In the byte formats, `out_valid` pulses for one cycle exactly `latency` cycles after the cycle in which the first beat of that pixel is on the bus.
- R8: `out_pix` changes only in a cycle where `out_valid` is 1, and holds its value otherwise. The rebuilt word is `{8'h00, word[15:0]}` for RGB565 and the full 24 bits for RGB888, where `word` is the pixel after any swap from R5.
- R9: While `line_start` is 1, `pix_ready` is 0. The next cycle has `bus_en` at 0. Any beats of a pixel that has not yet reached the output stage are discarded and never produce `out_valid`. The next pixel is rebuilt correctly.
- R10: While reset is held, `bus_en`, `out_valid`, `bus_data` and `out_pix` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Format select (see R1) |
| bgr_en | input | 1 | Exchange red and blue fields |
| line_start | input | 1 | Line-start pulse that clears byte alignment |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel accepted at this edge when valid |
| pix_data | input | 24 | Pixel word |
| bus_data | output | 16 | Bus beat; byte formats use [7:0] |
| bus_en | output | 1 | Beat present on the bus |
| out_pix | output | 24 | Rebuilt pixel word, held between strobes |
| out_valid | output | 1 | One-cycle strobe for a new rebuilt word |
| latency | output | 3 | Pipeline delay of the current format, in cycles |

## Verification
The case of interest is when the line-start pulse lands in the same cycle as two other events: the last byte of an RGB888 pixel sitting on the bus, and a new pixel being offered. Acceptance and alignment clearing then compete in one cycle. The bench drives `line_start` during that final beat while holding `pix_valid` high. It then checks three things: the new pixel is refused in that cycle, the bus goes quiet in the next cycle, and the interrupted pixel never yields an output strobe. It also checks that the pixel sent just after comes back intact, with exactly one strobe in total.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  typedef enum logic [1:0] {
    MODE_NATIVE16 = 2'b00,
    MODE_RGB565   = 2'b01,
    MODE_RGB888   = 2'b10,
    MODE_SPARE    = 2'b11
  } pxs_mode_e;

  // Bus beats needed to carry one pixel in a given format.
  function automatic logic [1:0] pxs_beats(pxs_mode_e m);
    case (m)
      MODE_RGB565: return 2'd2;
      MODE_RGB888: return 2'd3;
      default:     return 2'd1;
    endcase
  endfunction

  // Delay from first bus beat to rebuilt strobe.
  function automatic logic [2:0] pxs_delay(pxs_mode_e m);
    case (m)
      MODE_RGB565: return 3'd3;
      MODE_RGB888: return 3'd5;
      default:     return 3'd0;
    endcase
  endfunction

  function automatic logic pxs_is_byte(pxs_mode_e m);
    return (m == MODE_RGB565) || (m == MODE_RGB888);
  endfunction

endpackage

// File: rtl/pxs_rst_sync.sv
module pxs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pxs_fmt.sv
module pxs_fmt
  import pxs_pkg::*;
#(
  parameter int PIX_W  = 24,
  parameter int BYTE_W = 8
) (
  input  pxs_mode_e        mode,
  input  logic             bgr_en,
  input  logic [PIX_W-1:0] pix_i,
  output logic [PIX_W-1:0] pix_o
);
  // 16-bit field layout: red [15:11], green [10:5], blue [4:0]
  localparam int RB_W = 5;
  localparam int G_W  = 6;
  localparam int W16  = 2 * RB_W + G_W;

  logic [PIX_W-1:0] swap24;
  logic [PIX_W-1:0] swap16;

  always_comb begin
    swap24 = {pix_i[BYTE_W-1:0], pix_i[2*BYTE_W-1:BYTE_W], pix_i[PIX_W-1:2*BYTE_W]};
    swap16 = {pix_i[PIX_W-1:W16], pix_i[RB_W-1:0], pix_i[RB_W+G_W-1:RB_W],
              pix_i[W16-1:RB_W+G_W]};
    if (!bgr_en)                  pix_o = pix_i;
    else if (mode == MODE_RGB888) pix_o = swap24;
    else                          pix_o = swap16;
  end
endmodule

// File: rtl/pxs_serializer.sv
module pxs_serializer
  import pxs_pkg::*;
#(
  parameter int PIX_W  = 24,
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pxs_mode_e        mode,
  input  logic             line_start,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_word,
  output logic [BUS_W-1:0] bus_data,
  output logic             bus_en
);
  localparam int SH_W = PIX_W - BYTE_W;

  logic             en_q, en_d;
  logic [1:0]       ph_q, ph_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [BUS_W-1:0] dat_q, dat_d;
  logic [1:0]       last_ph;
  logic             at_last, take, byte_mode;

  always_comb begin
    last_ph   = pxs_beats(mode) - 2'd1;
    at_last   = (ph_q == last_ph);
    byte_mode = pxs_is_byte(mode);
    pix_ready = !line_start && (!en_q || at_last);
    take      = pix_valid && pix_ready;
  end

  always_comb begin
    en_d  = en_q;
    ph_d  = ph_q;
    sh_d  = sh_q;
    dat_d = dat_q;
    if (line_start) begin
      en_d = 1'b0;
      ph_d = 2'd0;
    end else if (take) begin
      en_d = 1'b1;
      ph_d = 2'd0;
      if (!byte_mode) begin
        dat_d = pix_word[BUS_W-1:0];
        sh_d  = '0;
      end else if (mode == MODE_RGB888) begin
        dat_d = BUS_W'(pix_word[PIX_W-1 -: BYTE_W]);
        sh_d  = pix_word[SH_W-1:0];
      end else begin
        dat_d = BUS_W'(pix_word[2*BYTE_W-1 -: BYTE_W]);
        sh_d  = {pix_word[BYTE_W-1:0], {(SH_W-BYTE_W){1'b0}}};
      end
    end else if (en_q && !at_last) begin
      ph_d  = ph_q + 2'd1;
      dat_d = BUS_W'(sh_q[SH_W-1 -: BYTE_W]);
      sh_d  = sh_q << BYTE_W;
    end else begin
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ph_q  <= 2'd0;
      sh_q  <= '0;
      dat_q <= '0;
    end else begin
      en_q  <= en_d;
      ph_q  <= ph_d;
      sh_q  <= sh_d;
      dat_q <= dat_d;
    end
  end

  assign bus_data = dat_q;
  assign bus_en   = en_q;

  AST_LS_QUIETS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !en_q); // R9
  AST_BEATS_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !at_last && !line_start) |=> (en_q && ph_q == $past(ph_q) + 2'd1)); // R1
  AST_TAKE_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (en_q && ph_q == 2'd0)); // R1
endmodule

// File: rtl/pxs_reassembler.sv
module pxs_reassembler
  import pxs_pkg::*;
#(
  parameter int PIX_W  = 24,
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pxs_mode_e        mode,
  input  logic             line_start,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             bus_en,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_valid
);
  localparam int ACC_W = PIX_W - BYTE_W;

  logic              in_v_q, in_v_d;
  logic [BYTE_W-1:0] in_b_q, in_b_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic              asm_v_q, asm_v_d;
  logic [PIX_W-1:0]  asm_w_q, asm_w_d;
  logic              st2_v_q, st2_v_d;
  logic [PIX_W-1:0]  st2_w_q, st2_w_d;
  logic [1:0]        last_cnt;
  logic              byte_mode, wide, fire;

  always_comb begin
    byte_mode = pxs_is_byte(mode);
    wide      = (mode == MODE_RGB888);
    last_cnt  = pxs_beats(mode) - 2'd1;
    fire      = byte_mode && in_v_q && (cnt_q == last_cnt) && !line_start;
  end

  // capture stage
  always_comb begin
    in_v_d = byte_mode && bus_en && !line_start;
    in_b_d = bus_en ? bus_data[BYTE_W-1:0] : in_b_q;
  end

  // collect stage
  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (line_start) begin
      cnt_d = 2'd0;
    end else if (in_v_q) begin
      cnt_d = (cnt_q == last_cnt) ? 2'd0 : cnt_q + 2'd1;
      acc_d = {acc_q[ACC_W-BYTE_W-1:0], in_b_q};
    end
  end

  // output stage, plus retiming stage for the wide word
  always_comb begin
    asm_v_d = fire;
    asm_w_d = asm_w_q;
    if (fire) begin
      if (wide) asm_w_d = {acc_q, in_b_q};
      else      asm_w_d = PIX_W'({acc_q[BYTE_W-1:0], in_b_q});
    end
    st2_v_d = asm_v_q && wide;
    st2_w_d = (asm_v_q && wide) ? asm_w_q : st2_w_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_v_q  <= 1'b0;
      in_b_q  <= '0;
      cnt_q   <= 2'd0;
      acc_q   <= '0;
      asm_v_q <= 1'b0;
      asm_w_q <= '0;
      st2_v_q <= 1'b0;
      st2_w_q <= '0;
    end else begin
      in_v_q  <= in_v_d;
      in_b_q  <= in_b_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      asm_v_q <= asm_v_d;
      asm_w_q <= asm_w_d;
      st2_v_q <= st2_v_d;
      st2_w_q <= st2_w_d;
    end
  end

  always_comb begin
    case (mode)
      MODE_RGB565: begin
        out_valid = asm_v_q;
        out_pix   = asm_w_q;
      end
      MODE_RGB888: begin
        out_valid = st2_v_q;
        out_pix   = st2_w_q;
      end
      default: begin
        out_valid = bus_en;
        out_pix   = PIX_W'(bus_data);
      end
    endcase
  end

  AST_LS_CLEARS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (!in_v_q && cnt_q == 2'd0)); // R9
  AST_STROBE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    asm_v_q |=> !asm_v_q); // R7
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(asm_w_q)); // R8
endmodule

// File: rtl/pxs_narrow_bus_top.sv
module pxs_narrow_bus_top
  import pxs_pkg::*;
#(
  parameter int PIX_W  = 24,
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8,
  parameter int LAT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             bgr_en,
  input  logic             line_start,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  output logic [BUS_W-1:0] bus_data,
  output logic             bus_en,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_valid,
  output logic [LAT_W-1:0] latency
);
  pxs_mode_e        mode;
  logic             rst_n_s;
  logic [PIX_W-1:0] word_fmt;

  assign mode    = pxs_mode_e'(mode_sel);
  assign latency = LAT_W'(pxs_delay(mode));

  pxs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pxs_fmt #(.PIX_W(PIX_W), .BYTE_W(BYTE_W)) u_fmt (
    .mode   (mode),
    .bgr_en (bgr_en),
    .pix_i  (pix_data),
    .pix_o  (word_fmt)
  );

  pxs_serializer #(.PIX_W(PIX_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .mode       (mode),
    .line_start (line_start),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .pix_word   (word_fmt),
    .bus_data   (bus_data),
    .bus_en     (bus_en)
  );

  pxs_reassembler #(.PIX_W(PIX_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_rsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .mode       (mode),
    .line_start (line_start),
    .bus_data   (bus_data),
    .bus_en     (bus_en),
    .out_pix    (out_pix),
    .out_valid  (out_valid)
  );

  AST_LAT_SHORT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == MODE_RGB565 && out_valid) |-> $past(bus_en, 2)); // R7
  AST_LAT_WIDE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == MODE_RGB888 && out_valid) |-> $past(bus_en, 3)); // R7
endmodule

// File: tb/pxs_narrow_bus_top_tb_top.sv
module pxs_narrow_bus_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic        bgr_en = 1'b0;
  logic        line_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [23:0] pix_data = '0;
  logic [15:0] bus_data;
  logic        bus_en;
  logic [23:0] out_pix;
  logic        out_valid;
  logic [2:0]  latency;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  logic [15:0] blog_d [0:63];
  int          blog_c [0:63];
  logic [23:0] olog_d [0:63];
  int          olog_c [0:63];
  int          nb = 0;
  int          no = 0;
  int          hold_bad = 0;
  logic [23:0] prev_out = '0;
  logic [23:0] px [0:7];
  int          acc_c [0:7];

  always #2 clk = ~clk;

  pxs_narrow_bus_top dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bgr_en(bgr_en),
    .line_start(line_start), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .bus_data(bus_data), .bus_en(bus_en),
    .out_pix(out_pix), .out_valid(out_valid), .latency(latency)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (bus_en && nb < 64) begin
        blog_d[nb] = bus_data; blog_c[nb] = cyc; nb++;
      end
      if (out_valid) begin
        if (no < 64) begin olog_d[no] = out_pix; olog_c[no] = cyc; no++; end
      end else if (out_pix !== prev_out) begin
        hold_bad++;
      end
    end
    prev_out = out_pix;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_word(int m, bit b, logic [23:0] p);
    logic [15:0] w16;
    if (m == 2) return b ? {p[7:0], p[15:8], p[23:16]} : p;
    w16 = b ? {p[4:0], p[10:5], p[15:11]} : p[15:0];
    return {8'h00, w16};
  endfunction

  task automatic clear_logs();
    @(negedge clk);
    nb = 0; no = 0; hold_bad = 0; prev_out = out_pix;
  endtask

  task automatic send_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1'b1; pix_data = px[i];
      #1;
      while (!pix_ready) begin @(negedge clk); #1; end
      acc_c[i] = cyc;
    end
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  // R10: values while reset is held
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(bus_en == 1'b0, "R10 bus_en in reset", 32'(bus_en), 0);
    chk(out_valid == 1'b0, "R10 out_valid in reset", 32'(out_valid), 0);
    chk(bus_data == 16'h0, "R10 bus_data in reset", 32'(bus_data), 0);
    chk(out_pix == 24'h0, "R10 out_pix in reset", 32'(out_pix), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // one format, n pixels back to back; tag names the byte-order requirement
  task automatic t_stream(int m, bit b, int n, string tag);
    int cpp, lat;
    logic [23:0] w;
    logic [15:0] eb;
    cpp = (m == 1) ? 2 : (m == 2) ? 3 : 1;
    lat = (m == 1) ? 3 : (m == 2) ? 5 : 0;
    @(negedge clk);
    mode_sel = 2'(m); bgr_en = b;
    repeat (4) @(negedge clk);
    clear_logs();
    for (int i = 0; i < n; i++) px[i] = 24'h3A5C91 + 24'(i * 24'h1F2E4D);
    send_n(n);
    repeat (14) @(negedge clk);
    chk(latency == 3'(lat), "R6 latency port", 32'(latency), 32'(lat));
    chk(nb == n * cpp, {tag, " R1 beat count"}, 32'(nb), 32'(n * cpp));
    chk(no == n, "R8 strobe count", 32'(no), 32'(n));
    chk(hold_bad == 0, "R8 out_pix changed without strobe", 32'(hold_bad), 0);
    for (int i = 1; i < n; i++)
      chk(acc_c[i] - acc_c[i-1] == cpp, "R1 accept spacing",
          32'(acc_c[i] - acc_c[i-1]), 32'(cpp));
    for (int i = 0; i < n; i++) begin
      w = exp_word(m, b, px[i]);
      for (int j = 0; j < cpp; j++) begin
        if (i * cpp + j < nb) begin
          if (cpp == 1) eb = w[15:0];
          else eb = {8'h00, 8'(w >> (8 * (cpp - 1 - j)))};
          chk(blog_d[i*cpp+j] == eb, b ? {tag, " R5 swapped beat"} : tag,
              32'(blog_d[i*cpp+j]), 32'(eb));
          chk(blog_c[i*cpp+j] == acc_c[i] + 1 + j, "R1 beat timing",
              32'(blog_c[i*cpp+j]), 32'(acc_c[i] + 1 + j));
        end
      end
      if (i < no && i * cpp < nb) begin
        chk(olog_d[i] == w, b ? "R5 rebuilt swapped word" : "R8 rebuilt word",
            32'(olog_d[i]), 32'(w));
        chk(olog_c[i] - blog_c[i*cpp] == lat, (cpp == 1) ? "R4 zero delay" : "R7 latency",
            32'(olog_c[i] - blog_c[i*cpp]), 32'(lat));
      end
    end
  endtask

  // R9: line start during the last beat while a new pixel is offered
  task automatic t_line_start();
    logic [23:0] p, q;
    p = 24'hC0FFEE; q = 24'h1234AB;
    @(negedge clk);
    mode_sel = 2'b10; bgr_en = 1'b0;
    repeat (4) @(negedge clk);
    clear_logs();
    @(negedge clk);
    pix_valid = 1'b1; pix_data = p;
    #1;
    chk(pix_ready == 1'b1, "R9 idle ready", 32'(pix_ready), 1);
    @(negedge clk);
    pix_valid = 1'b0;
    repeat (2) @(negedge clk);
    line_start = 1'b1; pix_valid = 1'b1; pix_data = q;
    #1;
    chk(pix_ready == 1'b0, "R9 ready low during line start", 32'(pix_ready), 0);
    @(negedge clk);
    line_start = 1'b0;
    chk(bus_en == 1'b0, "R9 bus quiet after line start", 32'(bus_en), 0);
    #1;
    chk(pix_ready == 1'b1, "R9 ready after line start", 32'(pix_ready), 1);
    @(negedge clk);
    pix_valid = 1'b0;
    repeat (14) @(negedge clk);
    chk(nb == 6, "R9 beat count", 32'(nb), 6);
    chk(no == 1, "R9 only the fresh pixel strobes", 32'(no), 1);
    if (no > 0) chk(olog_d[0] == q, "R9 fresh pixel intact", 32'(olog_d[0]), 32'(q));
  endtask

  initial begin
    t_reset();
    t_stream(0, 1'b0, 3, "R4 native beat");
    t_stream(3, 1'b0, 2, "R4 spare code beat");
    t_stream(0, 1'b1, 2, "R4 native beat");
    t_stream(1, 1'b0, 4, "R2 565 byte");
    t_stream(1, 1'b1, 3, "R2 565 byte");
    t_stream(2, 1'b0, 3, "R3 888 byte");
    t_stream(2, 1'b1, 2, "R3 888 byte");
    t_line_start();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule